// File: doc/BRIEF.md
# Key Event Register with Clear-on-Read

This block records key presses for a key matrix of three scan rows by thirteen columns. A scanning front end delivers the debounced state of every key once per completed scan, with a one-cycle strobe. The block compares each key with the state seen at the previous scan. A key that goes from released to pressed sets a sticky event bit, and that bit stays set until software has read it. Events from several scans merge into the same bits. The block keeps no queue, so it cannot tell the order of presses or whether a key was pressed more than once.

Software sees the events as six bytes, two per scan row, at byte addresses 0x40 to 0x45. Reads arrive on a valid/ready request channel and return on a valid/ready response channel. A single output register sits between the two. When the consumer holds the response, the request side stalls. Writes into the region are accepted and discarded.

An interrupt flag rises when a new event is latched. The event bits that were returned are cleared, and the flag drops, only when one unbroken burst reads 0x40 through 0x45 in order. A press that arrives while such a burst is in progress is kept for the next read.

Top module: `key_event_bank`

## Requirements
- R1: After reset, every event bit and every previous-state bit is 0, `irq` is 0, `rsp_valid` is 0, and `rd_ready` and `wr_ready` are 1.
- R2: Row r (0 to 2) is read as two bytes. The low byte is at 0x40+2r and carries key columns 1 to 8 in bits 0 to 7. The high byte is at 0x41+2r and carries columns 9 to 13 in bits 0 to 4, with bits 7:5 always 0. Key column c of row r is bit r*13+(c-1) of `scan_keys`. A read outside 0x40 to 0x45 returns 0x00.
- R3: An event bit is set on a clock edge where `scan_done` is 1, the key is 1 in `scan_keys`, and the key was 0 at the previous strobe. `scan_keys` is ignored while `scan_done` is 0.
- R4: Event bits accumulate by OR across scans until cleared. A key held pressed over many strobes sets its bit only once. It must be seen released at a strobe before a later press can set the bit again.
- R5: `irq` is 1 from the clock edge that latches a new event.
- R6: A clear happens only on a complete burst. The burst is accepted reads of 0x40, 0x41, 0x42, 0x43, 0x44 and 0x45 in that order, with `rd_valid` kept high between beats. A burst that starts at another address, is broken off, or is interrupted by any other read clears nothing.
- R7: Writes to the region have no effect on the event bits or on `irq`, and `wr_ready` is always 1.
- R8: When a burst completes, the bits that were returned are cleared. After that edge `irq` equals whether any event bit is still set.
- R9: An event latched during a burst is not lost. If its byte was already read, it stays set and appears in the next burst.
- R10: `rd_ready` is 1 when the response register is empty or being drained. While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_data` holds. Responses return one per accepted request, in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_done | input | 1 | One-cycle strobe at the end of each scan |
| scan_keys | input | 39 | Debounced pressed state of every key, sampled with `scan_done` |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request ready |
| rd_addr | input | 8 | Read byte address |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | 8 | Read response byte |
| wr_valid | input | 1 | Write request valid (discarded) |
| wr_ready | output | 1 | Write ready, always 1 |
| wr_addr | input | 8 | Write byte address (ignored) |
| wr_data | input | 8 | Write byte (ignored) |
| irq | output | 1 | Event pending flag |

## Verification
The assertions check the following on every cycle:
- `irq` always agrees with the presence of any event bit.
- Bits appear only at a scan strobe and disappear only at a completed burst.
- `irq` rises only after a strobe and falls only after a completed burst.
- A stalled response holds its data.
- High bytes return zeros in bits 7:5.

Only the bench scenarios can show the following:
- The exact byte and bit position of every key.
- That a held key is reported once.
- That partial or misplaced bursts leave the events in place.
- That a press arriving during a burst survives into the next one.

// File: rtl/key_evt_pkg.sv
package key_evt_pkg;
  localparam int BYTE_W     = 8;
  localparam int ROW_SLOT_W = 16;
  localparam int BYTES_PER_ROW = ROW_SLOT_W / BYTE_W;

  // byte index within the region that carries key k
  function automatic int key_byte(input int k, input int cols);
    return (k / cols) * BYTES_PER_ROW + (((k % cols) >= BYTE_W) ? 1 : 0);
  endfunction

  typedef enum logic {TRK_IDLE, TRK_RUN} trk_state_e;
endpackage

// File: rtl/kev_burst_track.sv
module kev_burst_track
  import key_evt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 'h40,
  parameter int NBYTES = 6,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic              rd_accept,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              in_region,
  output logic [IDX_W-1:0]  beat_idx,
  output logic              beat_start,
  output logic              beat_seq,
  output logic              burst_done
);
  localparam logic [ADDR_W-1:0] NB_A = ADDR_W'(NBYTES);
  localparam logic [IDX_W-1:0]  LAST = IDX_W'(NBYTES - 1);

  trk_state_e       st;
  logic [IDX_W-1:0] exp_idx;
  logic [ADDR_W-1:0] offs;
  logic             cont;

  assign offs       = rd_addr - BASE;
  assign in_region  = (rd_addr >= BASE) && (offs < NB_A);
  assign beat_idx   = offs[IDX_W-1:0];
  assign beat_start = rd_accept && in_region && (beat_idx == '0);
  assign cont       = rd_accept && in_region && (st == TRK_RUN) &&
                      (beat_idx == exp_idx) && !beat_start;
  assign beat_seq   = beat_start || cont;
  assign burst_done = beat_seq && (beat_idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= TRK_IDLE;
      exp_idx <= '0;
    end else if (rd_accept) begin
      if (beat_seq && !burst_done) begin
        st      <= TRK_RUN;
        exp_idx <= beat_idx + IDX_W'(1);
      end else begin
        st      <= TRK_IDLE;
      end
    end else if ((st == TRK_RUN) && !rd_valid) begin
      st <= TRK_IDLE;
    end
  end
endmodule

// File: rtl/kev_event_latch.sv
module kev_event_latch #(
  parameter int NKEYS = 39
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_done,
  input  logic [NKEYS-1:0] scan_keys,
  input  logic             clr_en,
  input  logic [NKEYS-1:0] clr_mask,
  output logic [NKEYS-1:0] key_bits,
  output logic             irq
);
  logic [NKEYS-1:0] prev_pressed;
  logic [NKEYS-1:0] new_ev;
  logic [NKEYS-1:0] bits_n;

  assign new_ev = scan_done ? (scan_keys & ~prev_pressed) : '0;
  assign bits_n = (clr_en ? (key_bits & ~clr_mask) : key_bits) | new_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_pressed <= '0;
      key_bits     <= '0;
      irq          <= 1'b0;
    end else begin
      if (scan_done) prev_pressed <= scan_keys;
      key_bits <= bits_n;
      if (clr_en) irq <= |bits_n;
      else        irq <= irq | (|new_ev);
    end
  end
endmodule

// File: rtl/kev_read_mask.sv
module kev_read_mask
  import key_evt_pkg::*;
#(
  parameter int COLS  = 13,
  parameter int NKEYS = 39,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_seq,
  input  logic             beat_start,
  input  logic [IDX_W-1:0] beat_idx,
  input  logic [NKEYS-1:0] key_bits,
  output logic [NKEYS-1:0] clr_mask
);
  logic [NKEYS-1:0] hit;
  logic [NKEYS-1:0] shown;

  for (genvar k = 0; k < NKEYS; k++) begin : g_hit
    localparam int KB = key_byte(k, COLS);
    assign hit[k] = beat_seq && (beat_idx == IDX_W'(KB));
  end

  assign clr_mask = (beat_start ? '0 : shown) | (key_bits & hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shown <= '0;
    else if (beat_seq) shown <= clr_mask;
  end
endmodule

// File: rtl/kev_rsp_stage.sv
module kev_rsp_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [W-1:0] req_data,
  output logic         req_ready,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_data
);
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (req_valid && req_ready) begin
      rsp_valid <= 1'b1;
      rsp_data  <= req_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/key_event_bank.sv
module key_event_bank
  import key_evt_pkg::*;
#(
  parameter int ROWS   = 3,
  parameter int COLS   = 13,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 'h40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scan_done,
  input  logic [ROWS*COLS-1:0]   scan_keys,
  input  logic                   rd_valid,
  output logic                   rd_ready,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [BYTE_W-1:0]      rsp_data,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [BYTE_W-1:0]      wr_data,
  output logic                   irq
);
  localparam int NKEYS  = ROWS * COLS;
  localparam int NBYTES = ROWS * BYTES_PER_ROW;
  localparam int IDX_W  = $clog2(NBYTES + 1);

  logic [NKEYS-1:0]           key_bits;
  logic [NKEYS-1:0]           clr_mask;
  logic [ROWS*ROW_SLOT_W-1:0] padded;
  logic                       rd_accept;
  logic                       in_region;
  logic [IDX_W-1:0]           beat_idx;
  logic                       beat_start;
  logic                       beat_seq;
  logic                       burst_done;
  logic [BYTE_W-1:0]          rd_byte;
  logic                       wr_unused;

  // write port: accepted and discarded
  assign wr_ready  = 1'b1;
  assign wr_unused = ^{wr_valid, wr_addr, wr_data};

  assign rd_accept = rd_valid && rd_ready;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign padded[r*ROW_SLOT_W +: ROW_SLOT_W] =
      {{(ROW_SLOT_W-COLS){1'b0}}, key_bits[r*COLS +: COLS]};
  end

  always_comb begin
    rd_byte = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (in_region && (beat_idx == IDX_W'(b))) rd_byte = padded[b*BYTE_W +: BYTE_W];
    end
  end

  kev_burst_track #(
    .ADDR_W(ADDR_W), .BASE(BASE), .NBYTES(NBYTES), .IDX_W(IDX_W)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_accept(rd_accept),
    .rd_addr(rd_addr), .in_region(in_region), .beat_idx(beat_idx),
    .beat_start(beat_start), .beat_seq(beat_seq), .burst_done(burst_done)
  );

  kev_read_mask #(
    .COLS(COLS), .NKEYS(NKEYS), .IDX_W(IDX_W)
  ) u_mask (
    .clk(clk), .rst_n(rst_n), .beat_seq(beat_seq), .beat_start(beat_start),
    .beat_idx(beat_idx), .key_bits(key_bits), .clr_mask(clr_mask)
  );

  kev_event_latch #(
    .NKEYS(NKEYS)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .scan_done(scan_done), .scan_keys(scan_keys),
    .clr_en(burst_done), .clr_mask(clr_mask), .key_bits(key_bits), .irq(irq)
  );

  kev_rsp_stage #(
    .W(BYTE_W)
  ) u_rsp (
    .clk(clk), .rst_n(rst_n), .req_valid(rd_valid), .req_data(rd_byte),
    .req_ready(rd_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data)
  );
endmodule

// File: rtl/key_event_bank_chk.sv
module key_event_bank_chk #(
  parameter int NKEYS  = 39,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 'h40,
  parameter int NBYTES = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scan_done,
  input logic              irq,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [7:0]        rsp_data,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_valid,
  input logic [NKEYS-1:0]  key_bits,
  input logic              burst_done
);
  logic [ADDR_W-1:0] offs;
  logic              hi_pend;

  assign offs = rd_addr - BASE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_pend <= 1'b0;
    else if (rd_valid && rd_ready)
      hi_pend <= (rd_addr >= BASE) && (offs < ADDR_W'(NBYTES)) && offs[0];
  end

  AST_IRQ_TRACKS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|key_bits)); // R8
  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && hi_pend) |-> (rsp_data[7:5] == 3'b000)); // R2
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R10
  AST_NO_SET_WITHOUT_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_done |=> ((key_bits & ~$past(key_bits)) == '0)); // R3
  AST_NO_CLEAR_WITHOUT_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_done |=> ((~key_bits & $past(key_bits)) == '0)); // R6
  AST_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !scan_done && !burst_done) |=> $stable(key_bits)); // R7
  AST_IRQ_RISE_ON_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(scan_done)); // R5
  AST_IRQ_FALL_ON_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(burst_done)); // R8
endmodule

bind key_event_bank key_event_bank_chk #(
  .NKEYS(NKEYS), .ADDR_W(ADDR_W), .BASE(BASE), .NBYTES(NBYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_done(scan_done), .irq(irq),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .wr_valid(wr_valid), .key_bits(key_bits), .burst_done(burst_done)
);

// File: tb/key_event_bank_bench.sv
module key_event_bank_bench;
  localparam int NK = 39;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scan_done = 1'b0;
  logic [NK-1:0] scan_keys = '0;
  logic          rd_valid = 1'b0;
  logic          rd_ready;
  logic [7:0]    rd_addr = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [7:0]    rsp_data;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [7:0]    wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [NK-1:0] model_bits = '0;
  logic [NK-1:0] model_prev = '0;
  logic [7:0]    got_b [0:5];

  always #2 clk = ~clk;

  key_event_bank u_key_event_bank (
    .clk(clk), .rst_n(rst_n), .scan_done(scan_done), .scan_keys(scan_keys),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_byte(input int b);
    int r = b / 2;
    if (b % 2 == 0) return model_bits[r*13 +: 8];
    return {3'b000, model_bits[r*13+8 +: 5]};
  endfunction

  function automatic logic [NK-1:0] pattern(input int p, input int salt);
    logic [NK-1:0] v = '0;
    for (int i = 0; i < NK; i++) v[i] = (((i * p) + salt) % 7) == 0;
    return v;
  endfunction

  task automatic scan(input logic [NK-1:0] keys);
    model_bits = model_bits | (keys & ~model_prev);
    model_prev = keys;
    scan_keys = keys;
    scan_done = 1'b1;
    @(posedge clk); @(negedge clk);
    scan_done = 1'b0;
    chk(irq == (|model_bits), "R5 irq after scan", irq, |model_bits);
  endtask

  task automatic do_read(input int first, input int n, input bit stall,
                         input int inj_beat, input logic [NK-1:0] inj);
    int idx = 0;
    int got = 0;
    int cyc = 0;
    bit injd = 0;
    bit acc;
    while (got < n) begin
      rsp_ready = !(stall && cyc >= 2 && cyc <= 4);
      rd_valid  = (idx < n);
      rd_addr   = 8'(first + idx);
      if (!injd && inj_beat == idx) begin
        scan_done = 1'b1; scan_keys = inj; injd = 1;
      end
      #1;
      if (rsp_valid && rsp_ready) begin got_b[got] = rsp_data; got++; end
      acc = rd_valid && rd_ready;
      @(posedge clk); @(negedge clk);
      scan_done = 1'b0;
      if (acc) idx++;
      cyc++;
    end
    rd_valid = 1'b0;
    rsp_ready = 1'b1;
  endtask

  task automatic check_full(input string tag, input bit stall);
    do_read(8'h40, 6, stall, -1, '0);
    for (int b = 0; b < 6; b++)
      chk(got_b[b] == model_byte(b), tag, got_b[b], model_byte(b));
    model_bits = '0;
    chk(irq == 1'b0, "R8 irq after full burst", irq, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(rd_ready == 1'b1 && wr_ready == 1'b1, "R1 ready", {rd_ready, wr_ready}, 3);
    rst_n = 1'b1;
    @(negedge clk);
    check_full("R1 empty read", 0);

    // R2 R3: every key alone at its byte and bit
    for (int k = 0; k < NK; k++) begin
      scan(NK'(1) << k);
      scan('0);
      check_full("R2 single key map", 0);
    end

    // R4 accumulation of separate presses
    for (int p = 1; p <= 30; p++) begin
      scan(pattern(p, 0));
      scan('0);
      scan(pattern(p, 3));
      scan(pattern(p, 5));
      check_full("R4 accumulate", 0);
    end

    // R4 held key reported only once
    scan(NK'(1) << 20);
    scan(NK'(1) << 20);
    check_full("R4 held first", 0);
    for (int i = 0; i < 3; i++) scan(NK'(1) << 20);
    chk(irq == 1'b0, "R4 held no reissue", irq, 0);
    check_full("R4 held empty", 0);
    scan('0);
    scan(NK'(1) << 20);
    chk(irq == 1'b1, "R4 repress", irq, 1);
    check_full("R4 repress read", 0);
    scan('0);

    // R3 scan_keys ignored without strobe
    scan_keys = '1;
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R3 no strobe", irq, 0);
    check_full("R3 no strobe read", 0);

    // R7 writes ignored
    scan(pattern(3, 1));
    scan('0);
    for (int i = 0; i < 6; i++) begin
      wr_valid = 1'b1; wr_addr = 8'(8'h40 + i); wr_data = 8'hFF;
      @(negedge clk);
      wr_valid = 1'b0; wr_addr = 8'(8'h40 + i); wr_data = 8'h00;
      @(negedge clk);
    end
    chk(irq == 1'b1, "R7 irq kept", irq, 1);
    check_full("R7 write ignored", 0);

    // R2 reads outside the region
    scan(pattern(2, 0));
    scan('0);
    do_read(8'h46, 1, 0, -1, '0);
    chk(got_b[0] == 8'h00, "R2 outside 0x46", got_b[0], 0);
    do_read(8'h3F, 1, 0, -1, '0);
    chk(got_b[0] == 8'h00, "R2 outside 0x3F", got_b[0], 0);

    // R6 partial and misplaced bursts clear nothing
    do_read(8'h40, 3, 0, -1, '0);
    for (int b = 0; b < 3; b++)
      chk(got_b[b] == model_byte(b), "R6 partial data", got_b[b], model_byte(b));
    chk(irq == 1'b1, "R6 partial keeps irq", irq, 1);
    do_read(8'h41, 5, 0, -1, '0);
    for (int b = 0; b < 5; b++)
      chk(got_b[b] == model_byte(b + 1), "R6 late start data", got_b[b], model_byte(b + 1));
    chk(irq == 1'b1, "R6 late start keeps irq", irq, 1);
    do_read(8'h40, 5, 0, -1, '0);
    chk(irq == 1'b1, "R6 short burst keeps irq", irq, 1);
    check_full("R6 full after partial", 0);

    // R9 press during a burst survives
    scan(NK'(1) << 15);
    scan('0);
    do_read(8'h40, 6, 0, 3, NK'(1));
    for (int b = 0; b < 6; b++)
      chk(got_b[b] == model_byte(b), "R9 burst data", got_b[b], model_byte(b));
    model_bits = NK'(1);
    model_prev = NK'(1);
    chk(irq == 1'b1, "R9 irq kept", irq, 1);
    check_full("R9 next burst", 0);
    scan('0);

    // R10 back-pressure on the response side
    for (int p = 1; p <= 6; p++) begin
      scan(pattern(p, 2));
      scan('0);
      check_full("R10 stalled burst", 1);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule